// File: doc/BRIEF.md
# Selectable-Edge Serial Load Port for a Current-Output Converter

This block is the digital front end of a current-output converter. It takes a framed serial stream on three asynchronous pins: a bit clock, a data line and an active-low frame select. It shifts 16-bit words into a holding register and acts on the 4-bit command at the top of each word. The result is either a new converter code, a change of the bit-clock edge used for capture, or a request to read the code back. A serial output carries the previous shift-register contents, so several devices can share one select line in a chain. After a readback request, the same output carries the current converter code during the next frame.

The pins are sampled by a fast system clock. Each pin passes through a two-stage synchroniser, and pin transitions are found by comparing successive synchronised samples. The bit clock must therefore run at no more than a quarter of the system clock rate. A word takes effect on its 16th capture edge; the design does not wait for the frame select to return high. A frame that ends early changes no converter state.

Top module: `dac_serial_if`

## Requirements
- R1: After reset, `dac_code` is 0, `dac_update` is 0, `sdo` is 0, the internal shift register holds 0, and bits are captured on the falling edge of `sclk_pin`.
- R2: A frame starts when `sync_n_pin` goes low. Transitions of `sclk_pin` while `sync_n_pin` is high do not shift, count or change any state.
- R3: Within a frame, `sdin_pin` is captured on each capture edge, most significant bit first. The word is acted on at the 16th capture edge with `sync_n_pin` still low. Further clock edges in that frame are ignored.
- R4: A word whose bits 15:12 are 0000 writes bits 11:0 into `dac_code`. `dac_update` is high for exactly one system clock cycle whenever `dac_code` is written, and at no other time.
- R5: Command 1011 makes the rising edge of `sclk_pin` the capture edge, and command 1010 makes it the falling edge. The change applies from the next frame on.
- R6: `sdo` takes the shift register's MSB when a frame starts, and again on each `sclk_pin` edge opposite to the capture edge inside the frame. A device downstream that samples `sdo` at capture edge k (k = 1..16) therefore sees bit 16-k of the word held before the frame.
- R7: Command 1001 replaces the shift register with {0000, `dac_code`}, so that the next frame shifts the current code out on `sdo`, MSB first.
- R8: If `sync_n_pin` rises before the 16th capture edge, `dac_code` and the capture edge are unchanged and `dac_update` stays low. Bits already shifted stay in the shift register.
- R9: Any other command value leaves `dac_code` and the capture edge unchanged. The received word stays in the shift register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_pin | input | 1 | Serial bit clock (asynchronous) |
| sdin_pin | input | 1 | Serial data in (asynchronous) |
| sync_n_pin | input | 1 | Active-low frame select (asynchronous) |
| dac_code | output | DATA_W (12) | Converter code register |
| dac_update | output | 1 | One-cycle pulse when `dac_code` is written |
| sdo | output | 1 | Serial out for chaining and readback |

## Verification
A wrong bit counter or capture-edge setting shows up within the same frame. `dac_code` takes a wrong value, or a strobe is missing or extra, a few system cycles after the 16th edge. Damage to the shift register stays hidden until the following frame, when the 16 bits on `sdo` fail to match the previous word, the partial abort remainder or the readback code. Every frame is therefore followed by another frame that observes `sdo`. A mode register that flips at the wrong time misaligns every later frame, so it is caught on the next load.

// File: rtl/dsi_pkg.sv
package dsi_pkg;
  localparam int WORD_W = 16;
  localparam int CMD_W  = 4;
  localparam int PAY_W  = WORD_W - CMD_W;

  typedef enum logic [CMD_W-1:0] {
    CMD_LOAD = 4'b0000,
    CMD_READ = 4'b1001,
    CMD_FALL = 4'b1010,
    CMD_RISE = 4'b1011
  } dsi_cmd_e;

  function automatic logic [CMD_W-1:0] cmd_field(input logic [WORD_W-1:0] w);
    return w[WORD_W-1 -: CMD_W];
  endfunction
endpackage

// File: rtl/dsi_sync.sv
module dsi_sync #(
  parameter int           W    = 3,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [1:0] stage;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage <= {2{INIT[i]}};
      else        stage <= {stage[0], d[i]};
    end
    assign q[i] = stage[1];
  end
endmodule

// File: rtl/dsi_edge.sv
module dsi_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_s,
  input  logic sync_n_s,
  input  logic rise_mode,
  output logic cap_evt,
  output logic launch_evt,
  output logic sync_fall,
  output logic sync_rise
);
  logic sclk_d, sync_d;
  logic sclk_up, sclk_dn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      sync_d <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      sync_d <= sync_n_s;
    end
  end

  assign sclk_up    = sclk_s & ~sclk_d;
  assign sclk_dn    = ~sclk_s & sclk_d;
  assign cap_evt    = rise_mode ? sclk_up : sclk_dn;
  assign launch_evt = rise_mode ? sclk_dn : sclk_up;
  assign sync_fall  = ~sync_n_s & sync_d;
  assign sync_rise  = sync_n_s & ~sync_d;
endmodule

// File: rtl/dsi_frame.sv
module dsi_frame #(
  parameter int WORD_W = 16,
  localparam int CNT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_evt,
  input  logic              sync_fall,
  input  logic              sync_rise,
  input  logic              sdin_s,
  input  logic              rb_load,
  input  logic [WORD_W-1:0] rb_word,
  output logic              frame_active,
  output logic              frame_start,
  output logic              frame_abort,
  output logic              exec_evt,
  output logic [WORD_W-1:0] word_next,
  output logic              sr_msb
);
  logic [WORD_W-1:0] sr;
  logic [CNT_W-1:0]  cnt;
  logic              active;
  logic              shift_evt;

  assign frame_start  = sync_fall;
  assign frame_abort  = active & sync_rise;
  assign shift_evt    = active & cap_evt & ~sync_rise;
  assign exec_evt     = shift_evt & (cnt == CNT_W'(WORD_W - 1));
  assign word_next    = {sr[WORD_W-2:0], sdin_s};
  assign sr_msb       = sr[WORD_W-1];
  assign frame_active = active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr     <= '0;
      cnt    <= '0;
      active <= 1'b0;
    end else if (frame_start) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (frame_abort) begin
      active <= 1'b0;
    end else if (shift_evt) begin
      sr  <= (exec_evt && rb_load) ? rb_word : word_next;
      cnt <= cnt + 1'b1;
      if (exec_evt) active <= 1'b0;
    end
  end
endmodule

// File: rtl/dac_serial_if.sv
module dac_serial_if #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_pin,
  input  logic              sdin_pin,
  input  logic              sync_n_pin,
  output logic [DATA_W-1:0] dac_code,
  output logic              dac_update,
  output logic              sdo
);
  import dsi_pkg::*;

  function automatic logic [DATA_W-1:0] data_field(input logic [WORD_W-1:0] w);
    return w[PAY_W-1 -: DATA_W];
  endfunction

  function automatic logic [WORD_W-1:0] rb_pack(input logic [DATA_W-1:0] c);
    logic [WORD_W-1:0] w;
    w = '0;
    w[PAY_W-1 -: DATA_W] = c;
    return w;
  endfunction

  logic [2:0] pins_s;
  logic sclk_s, sdin_s, sync_n_s;
  logic cap_evt, launch_evt, sync_fall, sync_rise;
  logic frame_active, frame_start, frame_abort, exec_evt, sr_msb;
  logic launch_upd, rb_load;
  logic [WORD_W-1:0] word_next;
  logic [CMD_W-1:0]  cmd;
  logic [DATA_W-1:0] code_q;
  logic upd_q, rise_q, sdo_q;

  dsi_sync #(.W(3), .INIT(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({sync_n_pin, sdin_pin, sclk_pin}), .q(pins_s)
  );
  assign sclk_s   = pins_s[0];
  assign sdin_s   = pins_s[1];
  assign sync_n_s = pins_s[2];

  dsi_edge u_edge (
    .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .sync_n_s(sync_n_s),
    .rise_mode(rise_q), .cap_evt(cap_evt), .launch_evt(launch_evt),
    .sync_fall(sync_fall), .sync_rise(sync_rise)
  );

  dsi_frame #(.WORD_W(WORD_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .cap_evt(cap_evt), .sync_fall(sync_fall),
    .sync_rise(sync_rise), .sdin_s(sdin_s), .rb_load(rb_load),
    .rb_word(rb_pack(code_q)), .frame_active(frame_active),
    .frame_start(frame_start), .frame_abort(frame_abort),
    .exec_evt(exec_evt), .word_next(word_next), .sr_msb(sr_msb)
  );

  assign cmd        = cmd_field(word_next);
  assign rb_load    = exec_evt && (cmd == CMD_READ);
  assign launch_upd = launch_evt & frame_active & ~sync_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      upd_q  <= 1'b0;
      rise_q <= 1'b0;
    end else begin
      upd_q <= 1'b0;
      if (exec_evt) begin
        case (cmd)
          CMD_LOAD: begin
            code_q <= data_field(word_next);
            upd_q  <= 1'b1;
          end
          CMD_RISE: rise_q <= 1'b1;
          CMD_FALL: rise_q <= 1'b0;
          default:  ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        sdo_q <= 1'b0;
    else if (frame_start || launch_upd) sdo_q <= sr_msb;
  end

  assign dac_code   = code_q;
  assign dac_update = upd_q;
  assign sdo        = sdo_q;
endmodule

// File: rtl/dac_serial_if_chk.sv
module dac_serial_if_chk #(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] dac_code,
  input logic              dac_update,
  input logic              sdo,
  input logic              rise_mode,
  input logic              exec_evt,
  input logic              launch_upd,
  input logic              frame_start,
  input logic              frame_abort
);
  assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dac_update |=> !dac_update);

  assert_code_with_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac_code) |-> dac_update);

  assert_strobe_after_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dac_update |-> $past(exec_evt));

  assert_abort_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_abort |=> (!dac_update && $stable(dac_code) && $stable(rise_mode)));

  assert_mode_on_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rise_mode) |-> $past(exec_evt));

  assert_sdo_on_launch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo) |-> $past(launch_upd || frame_start));
endmodule

bind dac_serial_if dac_serial_if_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dac_code(dac_code), .dac_update(dac_update),
  .sdo(sdo), .rise_mode(rise_q), .exec_evt(exec_evt),
  .launch_upd(launch_upd), .frame_start(frame_start),
  .frame_abort(frame_abort)
);

// File: tb/dac_serial_if_test.sv
`timescale 1ns/1ps
module dac_serial_if_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b1, sdin = 1'b0, sync_n = 1'b1;
  logic [11:0] dac_code;
  logic dac_update, sdo;
  int checks = 0, errors = 0, upd_cnt = 0;
  bit done = 0;

  logic [15:0] m_sr = '0;
  logic [11:0] m_code = '0;
  bit m_rise = 0;
  int exp_upd = 0;

  dac_serial_if uut (
    .clk(clk), .rst_n(rst_n), .sclk_pin(sclk), .sdin_pin(sdin),
    .sync_n_pin(sync_n), .dac_code(dac_code), .dac_update(dac_update), .sdo(sdo)
  );

  always #2.5 clk = ~clk;
  always @(negedge clk) if (dac_update === 1'b1) upd_cnt++;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // bench model of a completed word
  function automatic void model_exec(input logic [15:0] w);
    exp_upd = 0;
    case (w[15:12])
      4'b0000: begin m_code = w[11:0]; exp_upd = 1; m_sr = w; end
      4'b1001: m_sr = {4'b0000, m_code};
      4'b1011: begin m_rise = 1; m_sr = w; end
      4'b1010: begin m_rise = 0; m_sr = w; end
      default: m_sr = w;
    endcase
  endfunction

  task automatic frame(input logic [15:0] w, input int nbits,
                       input string stag, input string ctag);
    logic idle;
    idle = m_rise ? 1'b0 : 1'b1;
    sclk = idle;
    wclk(4);
    upd_cnt = 0;
    sync_n = 1'b0;
    wclk(4);
    for (int k = 0; k < nbits; k++) begin
      sdin = w[15-k];
      wclk(4);
      check(sdo === m_sr[15-k], stag, "sdo bit", int'(sdo), int'(m_sr[15-k]));
      sclk = ~idle;
      wclk(4);
      sclk = idle;
    end
    wclk(4);
    sync_n = 1'b1;
    wclk(6);
    if (nbits == 16) model_exec(w);
    else begin
      exp_upd = 0;
      for (int k = 0; k < nbits; k++) m_sr = {m_sr[14:0], w[15-k]};
    end
    check(dac_code === m_code, ctag, "dac_code", int'(dac_code), int'(m_code));
    check(upd_cnt == exp_upd, ctag, "strobe cycles", upd_cnt, exp_upd);
  endtask

  function automatic logic [15:0] rand_word(input int kind);
    logic [3:0] c;
    case (kind)
      0, 1, 2: c = 4'b0000;
      3: c = 4'b1001;
      4: c = 4'b1011;
      5: c = 4'b1010;
      default: begin
        c = 4'($urandom_range(1, 8));
        if (c == 4'b1001) c = 4'b1100;
      end
    endcase
    return {c, 12'($urandom)};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    wclk(3);
    rst_n = 1'b1;
    wclk(4);
    // R1: reset state
    check(dac_code === 12'h000, "R1", "reset code", int'(dac_code), 0);
    check(dac_update === 1'b0, "R1", "reset strobe", int'(dac_update), 0);
    check(sdo === 1'b0, "R1", "reset sdo", int'(sdo), 0);
    // R1/R3/R4: falling-edge load works straight after reset
    frame(16'h0A5C, 16, "R1", "R4");
    frame(16'h0FFF, 16, "R6", "R3");
    // R2: clock activity with frame select high
    for (int k = 0; k < 6; k++) begin sclk = ~sclk; sdin = k[0]; wclk(4); end
    check(dac_code === m_code, "R2", "code after idle clocks", int'(dac_code), int'(m_code));
    frame(16'h0123, 16, "R2", "R4");
    // R7: readback
    frame(16'h9000, 16, "R6", "R7");
    frame(16'h0456, 16, "R7", "R4");
    // R5: switch to rising edge, load, switch back
    frame(16'hB000, 16, "R6", "R5");
    frame(16'h0789, 16, "R6", "R5");
    frame(16'hA000, 16, "R6", "R5");
    frame(16'h0321, 16, "R6", "R5");
    // R8: aborted frames
    frame(16'h0EEE, 7, "R6", "R8");
    frame(16'h0000, 16, "R8", "R4");
    frame(16'h0DDD, 15, "R6", "R8");
    frame(16'h9000, 16, "R8", "R7");
    // R9: unused command
    frame(16'h5ABC, 16, "R7", "R9");
    frame(16'h0001, 16, "R9", "R4");
    // random mix
    for (int n = 0; n < 40; n++) begin
      int kind;
      kind = int'($urandom_range(0, 7));
      if (kind == 7) frame(rand_word(0), int'($urandom_range(1, 15)), "R6", "R8");
      else           frame(rand_word(kind), 16, "R6", "R3");
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule